// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that lets an external bus master read and write a bank of 8-bit control registers. SCL and SDA are brought into the system clock domain through a two-flop chain. The block detects START, repeated START and STOP conditions and compares the first seven bits of each transfer with its own device address. Bit 0 of that address comes from a strap pin.

In a write transfer, the first byte after the address loads a register pointer. Every byte after that is written to the register the pointer selects, and the pointer then advances by one. To read, the master sets the pointer with a write, issues a repeated START and sends the address with the read direction. The block then sends the register at the pointer. Each byte the master acknowledges advances the pointer and sends the next register. A missing acknowledge ends the burst.

The register bank sits outside the block. It sees a one-cycle write strobe with address and data, and a read port that returns data combinationally for the pointer address. The block never drives SDA high. It only asserts an output enable that pulls the line low.

Top module: `i2c_regfile_target`

## Requirements
- R1: The device address is 0x4C when `addr_strap_i` is 0 and 0x4D when it is 1 (the strap sets address bit 0). After the address byte, whose bit 0 is the direction, the block pulls SDA low during the ninth clock only when the seven address bits match.
- R2: On an address mismatch the block gives no acknowledge. It ignores every following bit and writes nothing, and the pointer is unchanged until the next START.
- R3: In a write transfer (direction 0), the first byte loads the pointer and is acknowledged. Each later byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R4: Each data byte of a write gives exactly one `reg_we_o` pulse, one system clock wide. The pulse comes after the eighth bit and before the acknowledge, while SCL is high and SDA is not being pulled. `reg_addr_o` carries the pointer and `reg_wdata_o` carries the byte.
- R5: After acknowledging an address with direction 1, the block sends the register at the pointer, MSB first. It changes its SDA drive only while SCL is low.
- R6: When the master acknowledges a read byte (SDA low on the ninth clock), the pointer advances and the next register is sent. When the master does not acknowledge (SDA high), the block releases SDA and stays released until a START or STOP.
- R7: The pointer wraps from 0xFF to 0x00.
- R8: The pointer is 0x00 after reset. It keeps its value across STOP, so a read without a new pointer write continues from the last position. `reg_addr_o` always shows the pointer.
- R9: A START or repeated START in any state, even in the middle of a byte, clears the bit count and restarts address reception.
- R10: SDA is only ever pulled low through `sda_oe_o`. The enable is 0 after reset, when the bus is idle, and while the block ignores a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap_i | input | 1 | Selects device address bit 0 |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 8 | Register pointer, used for both write and read |
| reg_wdata_o | output | 8 | Byte to be written |
| reg_rdata_i | input | 8 | Register contents at `reg_addr_o` |

## Verification
The bench targets several corner cases, each tied to the wrong behaviour it would expose:

- **Pointer wrap from 0xFF:** a design that saturates the pointer instead of wrapping would overwrite 0xFF twice.
- **Read resuming after STOP:** a design that clears the pointer on STOP would return register 0.
- **Master NACK followed by more clocking:** a design that keeps sending after the NACK would show bits other than all ones.
- **Bytes sent to a foreign address:** a design that keeps listening after a mismatch would acknowledge them, write them or move the pointer.
- **START after three address bits:** a design that does not reset the bit count on START would misalign the next address and stop acknowledging.
- **Strap change:** a design that ignores the strap would keep answering the wrong address.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } tgt_state_e;

  // Device address: upper six bits fixed, bit 0 from the strap.
  function automatic logic [6:0] own_addr(input logic [6:0] base, input logic strap);
    return {base[6:1], strap};
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // Bus conditions: data edge while the clock is held high.
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr_next(ptr);
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int BITS = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_s,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [6:0]      dev_addr,
  input  logic [BITS-1:0] rdata,
  output logic            ptr_load,
  output logic            ptr_inc,
  output logic [BITS-1:0] rx_byte,
  output logic            we,
  output logic            sda_oe,
  output tgt_state_e      state,
  output logic [3:0]      bit_cnt,
  output logic            ack_ph,
  output logic            addr_hit
);

  localparam logic [3:0] FULL = 4'(BITS);
  localparam logic [3:0] LAST = 4'(BITS - 1);

  logic [BITS-1:0] rx_sh;
  logic [BITS-1:0] tx_sh;
  logic            mack;
  logic            load_pend;
  logic            we_q;
  logic            cond;
  logic            ack_end;
  logic            wr_done;

  assign cond     = start_det | stop_det;
  assign addr_hit = (rx_sh[BITS-1:1] == dev_addr);
  assign ack_end  = scl_fall & ack_ph & ~cond;
  assign wr_done  = (state == ST_WR) & scl_rise & ~ack_ph & (bit_cnt == LAST) & ~cond;
  assign ptr_load = ack_end & (state == ST_PTR);
  assign ptr_inc  = ack_end & ((state == ST_WR) | ((state == ST_RD) & mack));
  assign rx_byte  = rx_sh;
  assign we       = we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      ack_ph    <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      mack      <= 1'b0;
      load_pend <= 1'b0;
      sda_oe    <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      we_q      <= wr_done;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (load_pend) begin
        // Register data for the new pointer is valid one cycle after the fall.
        tx_sh  <= rdata;
        sda_oe <= ~rdata[BITS-1];
      end else if (state != ST_IDLE && state != ST_SKIP) begin
        if (scl_rise) begin
          if (ack_ph) begin
            if (state == ST_RD) mack <= ~sda_s;
          end else if (bit_cnt < FULL) begin
            rx_sh   <= {rx_sh[BITS-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (ack_ph) begin
            ack_ph  <= 1'b0;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            case (state)
              ST_ADDR: begin
                if (rx_sh[0]) begin
                  state     <= ST_RD;
                  load_pend <= 1'b1;
                end else begin
                  state <= ST_PTR;
                end
              end
              ST_PTR: state <= ST_WR;
              ST_RD: begin
                if (mack) load_pend <= 1'b1;
                else      state     <= ST_SKIP;
              end
              default: ;
            endcase
          end else if (bit_cnt == FULL) begin
            case (state)
              ST_ADDR: begin
                if (addr_hit) begin
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                end else begin
                  state  <= ST_SKIP;
                  sda_oe <= 1'b0;
                end
              end
              ST_RD: begin
                ack_ph <= 1'b1;
                mack   <= 1'b0;
                sda_oe <= 1'b0;
              end
              default: begin
                ack_ph <= 1'b1;
                sda_oe <= 1'b1;
              end
            endcase
          end else if (state == ST_RD && bit_cnt != '0) begin
            tx_sh  <= {tx_sh[BITS-2:0], 1'b0};
            sda_oe <= ~tx_sh[BITS-2];
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_BASE = 7'h4C,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_strap_i,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);

  // Internal events, named for the bound checker.
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [6:0]        dev_addr;
  logic              ptr_load;
  logic              ptr_inc;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] ptr_q;
  tgt_state_e        state;
  logic [3:0]        bit_cnt;
  logic              ack_ph;
  logic              addr_hit;

  assign dev_addr = own_addr(DEV_ADDR_BASE, addr_strap_i);

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl #(.BITS(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rdata     (reg_rdata_i),
    .ptr_load  (ptr_load),
    .ptr_inc   (ptr_inc),
    .rx_byte   (rx_byte),
    .we        (reg_we_o),
    .sda_oe    (sda_oe_o),
    .state     (state),
    .bit_cnt   (bit_cnt),
    .ack_ph    (ack_ph),
    .addr_hit  (addr_hit)
  );

  i2c_tgt_ptr #(.AW(BYTE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (rx_byte),
    .inc      (ptr_inc),
    .ptr      (ptr_q)
  );

  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = rx_byte;

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input tgt_state_e state,
  input logic [3:0] bit_cnt,
  input logic       ack_ph,
  input logic       addr_hit
);

  // R4
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R4
  we_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (state == ST_WR && !ack_ph && !sda_oe_o));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe_o);

  // R5
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && bit_cnt == 4'd0 && !ack_ph));

  // R1
  ack_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && ack_ph && sda_oe_o) |-> addr_hit);

endmodule

bind i2c_regfile_target i2c_tgt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .state     (state),
  .bit_cnt   (bit_cnt),
  .ack_ph    (ack_ph),
  .addr_hit  (addr_hit)
);

// File: tb/tb_i2c_regfile_target.sv
`timescale 1ns/1ps
module tb_i2c_regfile_target;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b0;
  logic       sda_oe_o;
  logic       reg_we_o;
  logic [7:0] reg_addr_o;
  logic [7:0] reg_wdata_o;
  logic [7:0] reg_rdata_i;
  logic       sda_line;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int n_chk = 0;
  int n_fail = 0;
  int we_count = 0;
  int we_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line    = sda_m & ~sda_oe_o;
  assign reg_rdata_i = mem[reg_addr_o];

  i2c_regfile_target dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe_o),
    .addr_strap_i (strap),
    .reg_we_o     (reg_we_o),
    .reg_addr_o   (reg_addr_o),
    .reg_wdata_o  (reg_wdata_o),
    .reg_rdata_i  (reg_rdata_i)
  );

  // Register bank model and strobe monitor.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (reg_we_o) begin
      mem[reg_addr_o] <= reg_wdata_o;
      we_count <= we_count + 1;
      if (!(scl_m == 1'b1 && sda_oe_o == 1'b0)) we_bad <= we_bad + 1;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(5);
    scl_m = 1'b1; wt(10);
    sda_m = 1'b0; wt(10);
    scl_m = 1'b0; wt(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(5);
    scl_m = 1'b1; wt(10);
    sda_m = 1'b1; wt(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(5);
      scl_m = 1'b1; wt(10);
      scl_m = 1'b0; wt(5);
    end
    sda_m = 1'b1; wt(5);
    scl_m = 1'b1; wt(5);
    ack = ~sda_line; wt(5);
    scl_m = 1'b0; wt(5);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(5);
      scl_m = 1'b1; wt(5);
      b[i] = sda_line; wt(5);
      scl_m = 1'b0;
    end
    wt(5);
    sda_m = ~mack; wt(5);
    scl_m = 1'b1; wt(10);
    scl_m = 1'b0; wt(5);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R10", "oe after reset", 32'(sda_oe_o), 32'h0);
    chk("R8", "pointer after reset", 32'(reg_addr_o), 32'h0);
    chk("R4", "strobe after reset", 32'(reg_we_o), 32'h0);
  endtask

  task automatic t_write_burst();
    logic a;
    int w0;
    w0 = we_count;
    bus_start();
    send_byte({7'h4C, 1'b0}, a); chk("R1", "addr 4C ack", 32'(a), 32'h1);
    send_byte(8'h10, a);         chk("R3", "pointer ack", 32'(a), 32'h1);
    send_byte(8'hA5, a);         chk("R3", "data0 ack", 32'(a), 32'h1);
    send_byte(8'h3C, a);         chk("R3", "data1 ack", 32'(a), 32'h1);
    send_byte(8'h7E, a);         chk("R3", "data2 ack", 32'(a), 32'h1);
    bus_stop();
    exp_mem[8'h10] = 8'hA5; exp_mem[8'h11] = 8'h3C; exp_mem[8'h12] = 8'h7E;
    for (int i = 8'h10; i <= 8'h13; i++) chk("R3", "burst write content", 32'(mem[i]), 32'(exp_mem[i]));
    chk("R3", "pointer after burst", 32'(reg_addr_o), 32'h13);
    chk("R4", "strobe count", 32'(we_count - w0), 32'd3);
    chk("R4", "strobe placement", 32'(we_bad), 32'd0);
  endtask

  task automatic t_read_burst();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h4C, 1'b0}, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte({7'h4C, 1'b1}, a); chk("R5", "read addr ack", 32'(a), 32'h1);
    recv_byte(1'b1, d);          chk("R5", "read byte 10", 32'(d), 32'(exp_mem[8'h10]));
    recv_byte(1'b1, d);          chk("R6", "read byte 11", 32'(d), 32'(exp_mem[8'h11]));
    recv_byte(1'b0, d);          chk("R6", "read byte 12", 32'(d), 32'(exp_mem[8'h12]));
    bus_stop();
    chk("R6", "pointer after two acks", 32'(reg_addr_o), 32'h12);
    chk("R10", "oe released after stop", 32'(sda_oe_o), 32'h0);
  endtask

  task automatic t_mismatch();
    logic a;
    int w0;
    w0 = we_count;
    bus_start();
    send_byte({7'h4D, 1'b0}, a); chk("R2", "foreign addr no ack", 32'(a), 32'h0);
    send_byte(8'h20, a);         chk("R2", "ignored byte no ack", 32'(a), 32'h0);
    send_byte(8'h55, a);         chk("R2", "ignored data no ack", 32'(a), 32'h0);
    bus_stop();
    chk("R2", "pointer untouched", 32'(reg_addr_o), 32'h12);
    chk("R2", "no strobe", 32'(we_count - w0), 32'd0);
    chk("R2", "mem 20 untouched", 32'(mem[8'h20]), 32'(exp_mem[8'h20]));
  endtask

  task automatic t_strap();
    logic a;
    strap = 1'b1; wt(5);
    bus_start();
    send_byte({7'h4C, 1'b0}, a); chk("R1", "4C rejected with strap 1", 32'(a), 32'h0);
    bus_stop();
    bus_start();
    send_byte({7'h4D, 1'b0}, a); chk("R1", "4D accepted with strap 1", 32'(a), 32'h1);
    send_byte(8'h30, a);
    send_byte(8'h99, a);
    bus_stop();
    exp_mem[8'h30] = 8'h99;
    chk("R1", "write via 4D", 32'(mem[8'h30]), 32'(exp_mem[8'h30]));
    strap = 1'b0; wt(5);
  endtask

  task automatic t_wrap();
    logic a;
    bus_start();
    send_byte({7'h4C, 1'b0}, a);
    send_byte(8'hFE, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop();
    exp_mem[8'hFE] = 8'h11; exp_mem[8'hFF] = 8'h22; exp_mem[8'h00] = 8'h33;
    chk("R7", "mem FE", 32'(mem[8'hFE]), 32'h11);
    chk("R7", "mem FF", 32'(mem[8'hFF]), 32'h22);
    chk("R7", "mem 00 after wrap", 32'(mem[8'h00]), 32'h33);
    chk("R7", "pointer after wrap", 32'(reg_addr_o), 32'h01);
  endtask

  task automatic t_retain();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h4C, 1'b1}, a); chk("R8", "direct read ack", 32'(a), 32'h1);
    recv_byte(1'b0, d);          chk("R8", "read continues at 01", 32'(d), 32'(exp_mem[8'h01]));
    bus_stop();
    chk("R8", "pointer kept", 32'(reg_addr_o), 32'h01);
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({7'h4C, 1'b0}, a);
    send_byte(8'h40, a);
    bus_start();
    send_byte({7'h4C, 1'b1}, a);
    recv_byte(1'b0, d); chk("R6", "read byte 40", 32'(d), 32'(exp_mem[8'h40]));
    recv_byte(1'b0, d); chk("R6", "line released after nack", 32'(d), 32'hFF);
    bus_stop();
    chk("R6", "pointer not advanced by nack", 32'(reg_addr_o), 32'h40);
  endtask

  task automatic t_restart_midbyte();
    logic a;
    logic [2:0] part;
    part = 3'b100;
    bus_start();
    for (int i = 2; i >= 0; i--) begin
      sda_m = part[i]; wt(5);
      scl_m = 1'b1; wt(10);
      scl_m = 1'b0; wt(5);
    end
    bus_start();
    send_byte({7'h4C, 1'b0}, a); chk("R9", "ack after mid-byte restart", 32'(a), 32'h1);
    send_byte(8'h50, a);
    send_byte(8'h5A, a);
    bus_stop();
    exp_mem[8'h50] = 8'h5A;
    chk("R9", "write after restart", 32'(mem[8'h50]), 32'h5A);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_mismatch();
    t_strap();
    t_wrap();
    t_retain();
    t_nack_release();
    t_restart_midbyte();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule